// File: doc/BRIEF.md
# Read-Capture Delay and Bitslip Calibrator

This controller tunes the read-capture path of a multi-byte memory interface. It works through each byte lane in turn. For every bitslip position it sweeps all input-delay taps and asks an external pattern checker for an error count at each tap. From those counts it builds a weighted score that favours passing taps, and it keeps the bitslip with the highest score. It then applies that bitslip and searches for the read window. It steps the delay from zero up to the first clean tap, then keeps stepping until the first tap that fails again. Finally it sets the delay to the midpoint of that window.

All adjustments reach the PHY as short select-and-strobe sequences. For each one, a one-hot lane select goes up, a single reset or increment strobe fires, and the select drops to zero. Error counts arrive through a request/response handshake, and the controller waits as long as the checker needs. When every lane is done, the chosen bitslip and tap for each lane stay visible on status outputs and a done flag is raised.

Top module: `cal_read_level`

## Requirements
- R1: After reset, and until `start_i` is seen, no strobe, no lane select and no check request is active. `done_o` is low and both status buses are zero.
- R2: Every PHY adjustment drives `dly_sel_o` one-hot for the lane one cycle before the strobe and during it. The strobe lasts one cycle, at most one strobe is active at a time, and `dly_sel_o` is zero in the cycle after the strobe.
- R3: On `start_i`, each lane in ascending order receives a delay reset and then a bitslip reset before any check request is made. Lanes are then calibrated one after another, in ascending order.
- R4: A lane's search begins with one bitslip reset. For each bitslip position it issues a delay reset, then `NUM_TAPS` pairs of (check request, delay increment). It issues a bitslip increment between positions but not after the last one.
- R5: At each scanned tap the score grows by `MAX_ERR*NUM_TAPS` if the error count is zero, plus `MAX_ERR - min(err, MAX_ERR)`. Counts above `MAX_ERR` therefore add nothing.
- R6: A bitslip becomes the best only if its score is strictly greater than the best so far, so ties keep the lower index. The best is applied as one bitslip reset followed by exactly best-index bitslip increments.
- R7: The low edge is found as follows. After a delay reset, the controller checks tap 0, 1, 2 and so on, with one increment between checks. The first tap with zero errors is the low edge.
- R8: The high edge search starts after the low edge. The controller increments, checks, and stops at the first failing tap, which becomes the high edge. If no tap up to `NUM_TAPS-1` fails, the high edge is `NUM_TAPS`. If the low edge is `NUM_TAPS-1`, no further check is made.
- R9: The final tap is `((low + high) / 2) mod NUM_TAPS`. It is applied as a delay reset followed by that many delay increments, with at least `SETTLE_CYCLES` idle cycles after the reset and after each increment.
- R10: If no tap passes during the low-edge search, the final tap is 0. The delay is then left at its reset position.
- R11: `chk_valid_o` stays high with a stable `chk_mod_o` until `chk_ready_i` accepts it. No new request is made until `res_valid_i` returns an error count.
- R12: Lane m's chosen bitslip is at `slip_sel_o[m*SLIP_W +: SLIP_W]` and its tap at `tap_sel_o[m*TAP_W +: TAP_W]`. `done_o` goes high after the last lane and stays high with no activity until the next `start_i`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a full calibration |
| chk_valid_o | output | 1 | Pattern check request |
| chk_ready_i | input | 1 | Checker accepts request |
| chk_mod_o | output | MOD_W | Lane under test |
| res_valid_i | input | 1 | Error count valid |
| res_err_i | input | ERR_W | Error count |
| dly_sel_o | output | NUM_MODULES | One-hot lane select |
| dly_rst_o | output | 1 | Delay reset strobe |
| dly_inc_o | output | 1 | Delay increment strobe |
| slip_rst_o | output | 1 | Bitslip reset strobe |
| slip_inc_o | output | 1 | Bitslip increment strobe |
| done_o | output | 1 | All lanes calibrated |
| slip_sel_o | output | NUM_MODULES*SLIP_W | Chosen bitslip per lane |
| tap_sel_o | output | NUM_MODULES*TAP_W | Chosen tap per lane |

## Verification
The bench builds the block with 2 lanes, 8 taps, 4 bitslip positions, `MAX_ERR` 512 and `SETTLE_CYCLES` 3, so a whole three-scenario run stays at a few thousand cycles. With only 8 taps, these scenarios can reach a window that starts on the last tap, a window that runs past the last tap, a lane with no window, and bitslips whose scores tie. Error counts of 600 and 700 exceed `MAX_ERR` and exercise saturation. Four bitslips let the applied bitslip reach its highest index.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [1:0] {
    PK_DLY_RST,
    PK_DLY_INC,
    PK_SLIP_RST,
    PK_SLIP_INC
  } pulse_kind_e;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_SEL,
    PS_STB,
    PS_CLR
  } pulse_stage_e;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_INIT_D,
    ST_INIT_S,
    ST_SRCH_S0,
    ST_SCAN_D0,
    ST_SCAN_REQ,
    ST_SCAN_RES,
    ST_SCAN_INC,
    ST_SLIP_EVAL,
    ST_SLIP_INC,
    ST_APPLY_SR,
    ST_APPLY_SI,
    ST_CTR_D0,
    ST_LO_REQ,
    ST_LO_RES,
    ST_LO_INC,
    ST_HI_INC,
    ST_HI_REQ,
    ST_HI_RES,
    ST_SET_D0,
    ST_SET_W,
    ST_SET_I,
    ST_MOD_DONE,
    ST_DONE
  } cal_state_e;

endpackage

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen
  import cal_pkg::*;
#(
  parameter int NUM_MODULES = 2,
  parameter int MOD_W       = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  pulse_kind_e            kind_i,
  input  logic [MOD_W-1:0]       mod_i,
  output logic [NUM_MODULES-1:0] sel_o,
  output logic                   dly_rst_o,
  output logic                   dly_inc_o,
  output logic                   slip_rst_o,
  output logic                   slip_inc_o,
  output logic                   done_o
);

  pulse_stage_e           stage_q;
  pulse_kind_e            kind_q;
  logic [MOD_W-1:0]       mod_q;
  logic [NUM_MODULES-1:0] onehot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= PS_IDLE;
      kind_q  <= PK_DLY_RST;
      mod_q   <= '0;
    end else begin
      unique case (stage_q)
        PS_IDLE: if (req_i) begin
          stage_q <= PS_SEL;
          kind_q  <= kind_i;
          mod_q   <= mod_i;
        end
        PS_SEL:  stage_q <= PS_STB;
        PS_STB:  stage_q <= PS_CLR;
        default: stage_q <= PS_IDLE;
      endcase
    end
  end

  always_comb begin
    onehot        = '0;
    onehot[mod_q] = 1'b1;
  end

  assign sel_o      = (stage_q == PS_SEL || stage_q == PS_STB) ? onehot : '0;
  assign dly_rst_o  = (stage_q == PS_STB) && (kind_q == PK_DLY_RST);
  assign dly_inc_o  = (stage_q == PS_STB) && (kind_q == PK_DLY_INC);
  assign slip_rst_o = (stage_q == PS_STB) && (kind_q == PK_SLIP_RST);
  assign slip_inc_o = (stage_q == PS_STB) && (kind_q == PK_SLIP_INC);
  assign done_o     = (stage_q == PS_CLR);

  logic any_stb;
  assign any_stb = dly_rst_o | dly_inc_o | slip_rst_o | slip_inc_o;

  // R2
  strobe_sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |-> $countones(sel_o) == 1);
  // R2
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dly_rst_o, dly_inc_o, slip_rst_o, slip_inc_o}));
  // R2
  sel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |=> (sel_o == '0) && !any_stb);

endmodule

// File: rtl/cal_score.sv
module cal_score #(
  parameter int NUM_TAPS = 32,
  parameter int MAX_ERR  = 512,
  parameter int ERR_W    = 16,
  parameter int SLIP_W   = 3,
  parameter int SCORE_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_all_i,
  input  logic              clr_scan_i,
  input  logic              add_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              eval_i,
  input  logic [SLIP_W-1:0] slip_i,
  output logic [SLIP_W-1:0] best_slip_o
);

  localparam logic [31:0] MAX_E  = 32'(MAX_ERR);
  localparam logic [31:0] PASS_W = 32'(MAX_ERR * NUM_TAPS);

  logic [SCORE_W-1:0] score_q, best_q;
  logic [SLIP_W-1:0]  best_slip_q;
  logic [31:0]        err_ext, err_sat, term;

  always_comb begin
    err_ext = 32'(err_i);
    err_sat = (err_ext > MAX_E) ? MAX_E : err_ext;
    term    = ((err_i == '0) ? PASS_W : 32'd0) + (MAX_E - err_sat);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      score_q     <= '0;
      best_q      <= '0;
      best_slip_q <= '0;
    end else begin
      if (clr_scan_i) score_q <= '0;
      else if (add_i) score_q <= score_q + SCORE_W'(term);
      if (clr_all_i) begin
        best_q      <= '0;
        best_slip_q <= '0;
      end else if (eval_i && (score_q > best_q)) begin
        best_q      <= score_q;
        best_slip_q <= slip_i;
      end
    end
  end

  assign best_slip_o = best_slip_q;

  // R6
  best_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_all_i |=> best_q >= $past(best_q));

endmodule

// File: rtl/cal_window.sv
module cal_window #(
  parameter int TAP_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             min_we_i,
  input  logic [TAP_W:0]   min_val_i,
  input  logic             max_we_i,
  input  logic [TAP_W:0]   max_val_i,
  output logic [TAP_W-1:0] center_o
);

  logic [TAP_W:0]   min_q, max_q;
  logic             found_q;
  logic [TAP_W+1:0] sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q   <= '0;
      max_q   <= '0;
      found_q <= 1'b0;
    end else if (clr_i) begin
      min_q   <= '0;
      max_q   <= '0;
      found_q <= 1'b0;
    end else begin
      if (min_we_i) begin
        min_q   <= min_val_i;
        found_q <= 1'b1;
      end
      if (max_we_i) max_q <= max_val_i;
    end
  end

  assign sum      = {1'b0, min_q} + {1'b0, max_q};
  // midpoint wraps by truncation to TAP_W bits
  assign center_o = found_q ? sum[TAP_W:1] : '0;

  // R8
  max_after_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_we_i && found_q && !clr_i) |-> max_val_i > min_q);

endmodule

// File: rtl/cal_read_level.sv
module cal_read_level
  import cal_pkg::*;
#(
  parameter int NUM_MODULES   = 2,
  parameter int NUM_TAPS      = 32,
  parameter int NUM_SLIPS     = 8,
  parameter int MAX_ERR       = 512,
  parameter int ERR_W         = 16,
  parameter int SETTLE_CYCLES = 100,
  localparam int MOD_W  = (NUM_MODULES > 1) ? $clog2(NUM_MODULES) : 1,
  localparam int TAP_W  = $clog2(NUM_TAPS),
  localparam int SLIP_W = $clog2(NUM_SLIPS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  output logic                            chk_valid_o,
  input  logic                            chk_ready_i,
  output logic [MOD_W-1:0]                chk_mod_o,
  input  logic                            res_valid_i,
  input  logic [ERR_W-1:0]                res_err_i,
  output logic [NUM_MODULES-1:0]          dly_sel_o,
  output logic                            dly_rst_o,
  output logic                            dly_inc_o,
  output logic                            slip_rst_o,
  output logic                            slip_inc_o,
  output logic                            done_o,
  output logic [NUM_MODULES*SLIP_W-1:0]   slip_sel_o,
  output logic [NUM_MODULES*TAP_W-1:0]    tap_sel_o
);

  localparam int SCORE_W = $clog2(NUM_TAPS * (MAX_ERR * NUM_TAPS + MAX_ERR) + 1);
  localparam int WAIT_W  = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [TAP_W:0]    TAP_LAST  = (TAP_W+1)'(NUM_TAPS - 1);
  localparam logic [TAP_W:0]    TAP_END   = (TAP_W+1)'(NUM_TAPS);
  localparam logic [SLIP_W-1:0] SLIP_LAST = SLIP_W'(NUM_SLIPS - 1);
  localparam logic [MOD_W-1:0]  MOD_LAST  = MOD_W'(NUM_MODULES - 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(SETTLE_CYCLES - 1);

  cal_state_e         state_q;
  logic [MOD_W-1:0]   mod_q;
  logic [TAP_W:0]     tap_q;
  logic [SLIP_W-1:0]  slip_q, cnt_q;
  logic [TAP_W-1:0]   set_cnt_q;
  logic [WAIT_W-1:0]  wait_q;
  logic [SLIP_W-1:0]  slip_res_q [NUM_MODULES];
  logic [TAP_W-1:0]   tap_res_q  [NUM_MODULES];

  logic               pg_req, pg_done;
  pulse_kind_e        pg_kind;
  logic [SLIP_W-1:0]  best_slip;
  logic [TAP_W-1:0]   center;
  logic               res_pass;

  assign res_pass = (res_err_i == '0);

  always_comb begin
    pg_req  = 1'b1;
    pg_kind = PK_DLY_RST;
    unique case (state_q)
      ST_INIT_D, ST_SCAN_D0, ST_CTR_D0, ST_SET_D0: pg_kind = PK_DLY_RST;
      ST_INIT_S, ST_SRCH_S0, ST_APPLY_SR:          pg_kind = PK_SLIP_RST;
      ST_SCAN_INC, ST_LO_INC, ST_HI_INC, ST_SET_I: pg_kind = PK_DLY_INC;
      ST_SLIP_INC, ST_APPLY_SI:                    pg_kind = PK_SLIP_INC;
      default:                                     pg_req  = 1'b0;
    endcase
  end

  cal_pulse_gen #(
    .NUM_MODULES(NUM_MODULES),
    .MOD_W      (MOD_W)
  ) u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (pg_req),
    .kind_i    (pg_kind),
    .mod_i     (mod_q),
    .sel_o     (dly_sel_o),
    .dly_rst_o (dly_rst_o),
    .dly_inc_o (dly_inc_o),
    .slip_rst_o(slip_rst_o),
    .slip_inc_o(slip_inc_o),
    .done_o    (pg_done)
  );

  cal_score #(
    .NUM_TAPS(NUM_TAPS),
    .MAX_ERR (MAX_ERR),
    .ERR_W   (ERR_W),
    .SLIP_W  (SLIP_W),
    .SCORE_W (SCORE_W)
  ) u_score (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_all_i  (state_q == ST_SRCH_S0 && pg_done),
    .clr_scan_i (state_q == ST_SCAN_D0 && pg_done),
    .add_i      (state_q == ST_SCAN_RES && res_valid_i),
    .err_i      (res_err_i),
    .eval_i     (state_q == ST_SLIP_EVAL),
    .slip_i     (slip_q),
    .best_slip_o(best_slip)
  );

  cal_window #(
    .TAP_W(TAP_W)
  ) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_CTR_D0 && pg_done),
    .min_we_i (state_q == ST_LO_RES && res_valid_i && res_pass),
    .min_val_i(tap_q),
    .max_we_i (res_valid_i &&
               ((state_q == ST_LO_RES && res_pass && tap_q == TAP_LAST) ||
                (state_q == ST_HI_RES && (!res_pass || tap_q == TAP_LAST)))),
    .max_val_i((state_q == ST_HI_RES && !res_pass) ? tap_q : TAP_END),
    .center_o (center)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mod_q     <= '0;
      tap_q     <= '0;
      slip_q    <= '0;
      cnt_q     <= '0;
      set_cnt_q <= '0;
      wait_q    <= '0;
      for (int i = 0; i < NUM_MODULES; i++) begin
        slip_res_q[i] <= '0;
        tap_res_q[i]  <= '0;
      end
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          mod_q   <= '0;
          state_q <= ST_INIT_D;
        end
        ST_INIT_D: if (pg_done) state_q <= ST_INIT_S;
        ST_INIT_S: if (pg_done) begin
          if (mod_q == MOD_LAST) begin
            mod_q   <= '0;
            state_q <= ST_SRCH_S0;
          end else begin
            mod_q   <= mod_q + 1'b1;
            state_q <= ST_INIT_D;
          end
        end
        ST_SRCH_S0: if (pg_done) begin
          slip_q  <= '0;
          state_q <= ST_SCAN_D0;
        end
        ST_SCAN_D0: if (pg_done) begin
          tap_q   <= '0;
          state_q <= ST_SCAN_REQ;
        end
        ST_SCAN_REQ: if (chk_ready_i) state_q <= ST_SCAN_RES;
        ST_SCAN_RES: if (res_valid_i) state_q <= ST_SCAN_INC;
        ST_SCAN_INC: if (pg_done) begin
          if (tap_q == TAP_LAST) state_q <= ST_SLIP_EVAL;
          else begin
            tap_q   <= tap_q + 1'b1;
            state_q <= ST_SCAN_REQ;
          end
        end
        ST_SLIP_EVAL: state_q <= (slip_q == SLIP_LAST) ? ST_APPLY_SR : ST_SLIP_INC;
        ST_SLIP_INC: if (pg_done) begin
          slip_q  <= slip_q + 1'b1;
          state_q <= ST_SCAN_D0;
        end
        ST_APPLY_SR: if (pg_done) begin
          cnt_q   <= '0;
          state_q <= (best_slip == '0) ? ST_CTR_D0 : ST_APPLY_SI;
        end
        ST_APPLY_SI: if (pg_done) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q + 1'b1 == best_slip) state_q <= ST_CTR_D0;
        end
        ST_CTR_D0: if (pg_done) begin
          tap_q   <= '0;
          state_q <= ST_LO_REQ;
        end
        ST_LO_REQ: if (chk_ready_i) state_q <= ST_LO_RES;
        ST_LO_RES: if (res_valid_i) begin
          if (tap_q == TAP_LAST) state_q <= ST_SET_D0;
          else                   state_q <= res_pass ? ST_HI_INC : ST_LO_INC;
        end
        ST_LO_INC: if (pg_done) begin
          tap_q   <= tap_q + 1'b1;
          state_q <= ST_LO_REQ;
        end
        ST_HI_INC: if (pg_done) begin
          tap_q   <= tap_q + 1'b1;
          state_q <= ST_HI_REQ;
        end
        ST_HI_REQ: if (chk_ready_i) state_q <= ST_HI_RES;
        ST_HI_RES: if (res_valid_i) begin
          state_q <= (!res_pass || tap_q == TAP_LAST) ? ST_SET_D0 : ST_HI_INC;
        end
        ST_SET_D0: if (pg_done) begin
          set_cnt_q <= '0;
          wait_q    <= '0;
          state_q   <= ST_SET_W;
        end
        ST_SET_W: begin
          if (wait_q == WAIT_LAST) begin
            wait_q  <= '0;
            state_q <= (set_cnt_q == center) ? ST_MOD_DONE : ST_SET_I;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_SET_I: if (pg_done) begin
          set_cnt_q <= set_cnt_q + 1'b1;
          state_q   <= ST_SET_W;
        end
        ST_MOD_DONE: begin
          slip_res_q[mod_q] <= best_slip;
          tap_res_q[mod_q]  <= center;
          if (mod_q == MOD_LAST) state_q <= ST_DONE;
          else begin
            mod_q   <= mod_q + 1'b1;
            state_q <= ST_SRCH_S0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign chk_valid_o = (state_q == ST_SCAN_REQ) || (state_q == ST_LO_REQ) ||
                       (state_q == ST_HI_REQ);
  assign chk_mod_o   = mod_q;
  assign done_o      = (state_q == ST_DONE);

  for (genvar g = 0; g < NUM_MODULES; g++) begin : g_status
    assign slip_sel_o[g*SLIP_W +: SLIP_W] = slip_res_q[g];
    assign tap_sel_o[g*TAP_W +: TAP_W]    = tap_res_q[g];
  end

  // R11
  chk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_o && !chk_ready_i) |=> chk_valid_o && $stable(chk_mod_o));
  // R11
  no_req_in_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_o && chk_ready_i) |=> !chk_valid_o);
  // R12
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !chk_valid_o && (dly_sel_o == '0));

endmodule

// File: tb/tb_cal_read_level.sv
module tb_cal_read_level;

  localparam int CLK_PERIOD = 10;
  localparam int NM     = 2;
  localparam int NT     = 8;
  localparam int NS     = 4;
  localparam int MAXE   = 512;
  localparam int ERRW   = 16;
  localparam int SETTLE = 3;
  localparam int MODW   = 1;
  localparam int TAPW   = 3;
  localparam int SLIPW  = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic chk_valid_o, chk_ready_i, res_valid_i;
  logic [MODW-1:0] chk_mod_o;
  logic [ERRW-1:0] res_err_i;
  logic [NM-1:0] dly_sel_o;
  logic dly_rst_o, dly_inc_o, slip_rst_o, slip_inc_o, done_o;
  logic [NM*SLIPW-1:0] slip_sel_o;
  logic [NM*TAPW-1:0] tap_sel_o;

  cal_read_level #(
    .NUM_MODULES(NM), .NUM_TAPS(NT), .NUM_SLIPS(NS),
    .MAX_ERR(MAXE), .ERR_W(ERRW), .SETTLE_CYCLES(SETTLE)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .chk_valid_o(chk_valid_o), .chk_ready_i(chk_ready_i), .chk_mod_o(chk_mod_o),
    .res_valid_i(res_valid_i), .res_err_i(res_err_i),
    .dly_sel_o(dly_sel_o), .dly_rst_o(dly_rst_o), .dly_inc_o(dly_inc_o),
    .slip_rst_o(slip_rst_o), .slip_inc_o(slip_inc_o), .done_o(done_o),
    .slip_sel_o(slip_sel_o), .tap_sel_o(tap_sel_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // event kinds: 0 delay reset, 1 delay inc, 2 bitslip reset, 3 bitslip inc, 4 check
  typedef struct {
    int    kind;
    int    mod;
    int    tap;
    int    slip;
    int    gap;
    string req;
  } ev_t;

  ev_t exp_q[$];
  int  main_checks = 0, main_errors = 0;
  int  mon_checks = 0, mon_errors = 0;
  int  scen = 0;
  int  exp_slip[NM], exp_tap[NM];
  bit  finished = 1'b0;

  function automatic int err_of(int m, int s, int t);
    int e;
    e = 1;
    case (scen)
      0: if (m == 0) e = (s == 2 && t >= 2 && t <= 5) ? 0 : 3 + t;
         else        e = (s == 1 && t >= 5) ? 0 : 10 + s;
      1: if (m == 0) e = (t >= 1 && t <= 3) ? 0 : 5;
         else        e = (s == 0) ? 700 : (s == 1) ? 600 : (s == 2) ? 100 : 50;
      default:
         if (m == 0) e = (s == 3 && t == 7) ? 0 : 1;
         else        e = (s == 1 && (t == 0 || t >= 5)) ? 0 : 2;
    endcase
    return e;
  endfunction

  task automatic chk_main(bit ok, string req, int act, int expv);
    main_checks++;
    if (!ok) begin
      main_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push(int kind, int m, int t, int s, int gap, string req);
    ev_t e;
    e.kind = kind; e.mod = m; e.tap = t; e.slip = s; e.gap = gap; e.req = req;
    exp_q.push_back(e);
  endtask

  // driver: expected event stream from the requirements
  task automatic build_expected();
    longint sc, best_sc;
    int best, mn, mx, ctr, t;
    bit found;
    for (int m = 0; m < NM; m++) begin
      push(0, m, 0, 0, 0, "R3");
      push(2, m, 0, 0, 0, "R3");
    end
    for (int m = 0; m < NM; m++) begin
      push(2, m, 0, 0, 0, "R4");
      best = 0; best_sc = 0;
      for (int s = 0; s < NS; s++) begin
        push(0, m, 0, 0, 0, "R4");
        sc = 0;
        for (int tt = 0; tt < NT; tt++) begin
          int e, es;
          push(4, m, tt, s, 0, "R4");
          e  = err_of(m, s, tt);
          es = (e > MAXE) ? MAXE : e;
          sc += ((e == 0) ? MAXE * NT : 0) + (MAXE - es);
          push(1, m, 0, 0, 0, "R4");
        end
        if (sc > best_sc) begin best_sc = sc; best = s; end
        if (s < NS - 1) push(3, m, 0, 0, 0, "R4");
      end
      push(2, m, 0, 0, 0, "R6");
      for (int i = 0; i < best; i++) push(3, m, 0, 0, 0, "R6");
      push(0, m, 0, 0, 0, "R7");
      found = 0; mn = 0;
      for (int tt = 0; tt < NT; tt++) begin
        push(4, m, tt, best, 0, "R7");
        if (err_of(m, best, tt) == 0) begin mn = tt; found = 1; break; end
        if (tt < NT - 1) push(1, m, 0, 0, 0, "R7");
      end
      ctr = 0;
      if (found) begin
        mx = NT; t = mn;
        while (t < NT - 1) begin
          push(1, m, 0, 0, 0, "R8");
          t++;
          push(4, m, t, best, 0, "R8");
          if (err_of(m, best, t) != 0) begin mx = t; break; end
        end
        ctr = ((mn + mx) / 2) % NT;
      end
      push(0, m, 0, 0, 0, "R9");
      for (int i = 0; i < ctr; i++) push(1, m, 0, 0, SETTLE + 1, "R9");
      exp_slip[m] = best;
      exp_tap[m]  = ctr;
    end
  endtask

  // monitor and checker model
  int trk_tap[NM], trk_slip[NM];
  int cyc, last_stb, resp_cnt, resp_val;
  bit pend_clr;
  logic [NM-1:0] prev_sel;

  task automatic chk_mon(bit ok, string req, int act, int expv);
    mon_checks++;
    if (!ok) begin
      mon_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_ni) begin
      chk_ready_i = 1'b0;
      res_valid_i = 1'b0;
      res_err_i   = '0;
      resp_cnt = 0; cyc = 0; last_stb = 0; pend_clr = 0; prev_sel = '0;
      for (int i = 0; i < NM; i++) begin trk_tap[i] = 0; trk_slip[i] = 0; end
    end else begin
      int k, m;
      bit rdy;
      ev_t e;
      cyc++;
      if (resp_cnt > 0) begin
        resp_cnt--;
        if (resp_cnt == 0) begin
          res_valid_i = 1'b1;
          res_err_i   = ERRW'(resp_val);
        end
      end else res_valid_i = 1'b0;

      k = dly_rst_o ? 0 : dly_inc_o ? 1 : slip_rst_o ? 2 : slip_inc_o ? 3 : -1;
      if (k >= 0) begin
        m = 0;
        for (int i = 0; i < NM; i++) if (dly_sel_o[i]) m = i;
        chk_mon($countones(dly_sel_o) == 1, "R2", $countones(dly_sel_o), 1);
        chk_mon(prev_sel == dly_sel_o, "R2", prev_sel, dly_sel_o);
        if (exp_q.size() == 0) chk_mon(1'b0, "R3", k, -1);
        else begin
          e = exp_q.pop_front();
          chk_mon(e.kind == k, e.req, k, e.kind);
          chk_mon(e.mod == m, e.req, m, e.mod);
          if (e.gap > 0) chk_mon(cyc - last_stb >= e.gap, e.req, cyc - last_stb, e.gap);
        end
        case (k)
          0: trk_tap[m] = 0;
          1: trk_tap[m] = (trk_tap[m] + 1) % NT;
          2: trk_slip[m] = 0;
          default: trk_slip[m] = (trk_slip[m] + 1) % NS;
        endcase
        last_stb = cyc;
        pend_clr = 1;
      end else if (pend_clr) begin
        chk_mon(dly_sel_o == '0, "R2", dly_sel_o, 0);
        pend_clr = 0;
      end

      rdy = (cyc % 3) != 1;
      chk_ready_i = rdy;
      if (chk_valid_o && rdy) begin
        m = int'(chk_mod_o);
        if (exp_q.size() == 0) chk_mon(1'b0, "R4", 4, -1);
        else begin
          e = exp_q.pop_front();
          chk_mon(e.kind == 4, e.req, 4, e.kind);
          chk_mon(e.mod == m, "R11", m, e.mod);
          chk_mon(e.tap == trk_tap[m], e.req, trk_tap[m], e.tap);
          chk_mon(e.slip == trk_slip[m], e.req, trk_slip[m], e.slip);
        end
        resp_val = err_of(m, trk_slip[m], trk_tap[m]);
        resp_cnt = 1 + (cyc % 3);
      end
      prev_sel = dly_sel_o;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors",
               main_checks + mon_checks, main_errors + mon_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    main_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet during reset and idle after it
    chk_main(!done_o && !chk_valid_o && dly_sel_o == '0, "R1", done_o, 0);
    chk_main(slip_sel_o == '0 && tap_sel_o == '0, "R1", int'(tap_sel_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk_main(!chk_valid_o && !dly_rst_o && !slip_rst_o && dly_sel_o == '0, "R1",
             chk_valid_o, 0);
    for (int sc = 0; sc < 3; sc++) begin
      int w;
      scen = sc;
      build_expected();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      chk_main(!done_o, "R12", done_o, 0);
      w = 0;
      while (!done_o && w < 40000) begin @(negedge clk); w++; end
      chk_main(done_o, "R12", done_o, 1);
      for (int m = 0; m < NM; m++) begin
        int gs, gt;
        gs = int'(slip_sel_o[m*SLIPW +: SLIPW]);
        gt = int'(tap_sel_o[m*TAPW +: TAPW]);
        // scenario 1 lane 1 needs saturation (R5); ties keep lower index (R6)
        chk_main(gs == exp_slip[m], "R5/R6", gs, exp_slip[m]);
        // center from the window (R9); no window gives 0 (R10)
        chk_main(gt == exp_tap[m], "R9/R10", gt, exp_tap[m]);
      end
      chk_main(exp_q.size() == 0, "R3", exp_q.size(), 0);
      repeat (4) @(negedge clk);
      chk_main(done_o && !chk_valid_o && dly_sel_o == '0, "R12", done_o, 1);
      exp_q.delete();
    end
    finish_run();
  end

endmodule